// File: doc/BRIEF.md
# External Memory Bus Write Controller

This block lets a small processor core reach an external parallel memory through table-style reads and writes. A request names an address, a direction and one data byte. The controller claims the bus pins and drives the address and the data lanes. It raises the read strobe or the right mix of write strobes and byte enables. It holds them for a programmable number of wait cycles, and then reports completion with a one-cycle done pulse.

An 8-bit control register sets the behaviour. Bit 7 is the bus-release flag, bits 5:4 are the wait code and bits 1:0 are the wide-write mode. The mode picks how a single byte reaches a 16-bit data bus: as a byte with its own write strobe, as a byte with a shared high strobe and a byte enable, or paired with the previous even-address byte into a full word. The release flag decides whether the pins stay with the bus at all times or go back to general I/O between accesses.

The sequencer has four named states. ST_IDLE waits for a request. On a request it moves to ST_FIN when the request is an even-address word-mode write, and to ST_ACCESS otherwise. ST_ACCESS is the first strobe cycle. From it the sequencer moves to ST_FIN when no wait is selected, and to ST_STALL otherwise. ST_STALL holds the strobes and moves to ST_FIN when its count runs out. ST_FIN drives the done pulse and always returns to ST_IDLE.

Top module: `ext_bus_ctl`

## Requirements
- R1: After reset, cfg_rdata is 0x00, busy and done are 0, bus_own is 1, and every strobe (wr_hi, wr_lo, en_hi, en_lo, rd_stb) and bus_drive are 0.
- R2: A cfg_we write stores bits 7, 5, 4, 1 and 0 of cfg_wdata. Bits 6, 3 and 2 always read back as 0 on cfg_rdata, which shows the new value from the cycle after the write.
- R3: While internal_only is 1, cfg_we writes are ignored and cfg_rdata keeps its previous value.
- R4: With bit 7 at 0, bus_own is 1 at all times. With bit 7 at 1, bus_own is 1 only while busy is 1 and 0 otherwise.
- R5: An access keeps busy high for 1+W cycles, starting the cycle after the request. W is 0, 1, 2 or 3 for wait codes 11, 10, 01 and 00. done is high for exactly the one cycle after busy falls, and all strobes are low in that cycle.
- R6: Byte-write mode (mode 00, wide=1): the write byte appears on both halves of bus_dout. Address bit 0 = 0 raises wr_lo only, and address bit 0 = 1 raises wr_hi only. en_hi and en_lo stay 0.
- R7: Byte-select mode (mode 01, wide=1): the byte appears on both halves. wr_hi is raised together with en_lo when address bit 0 = 0, or with en_hi when it is 1. wr_lo stays 0.
- R8: Word mode (mode 10 or 11, wide=1): an even-address write only stores its byte. busy stays 0, no strobe rises, and done pulses the next cycle. An odd-address write then drives {this byte, stored byte} on bus_dout and raises wr_hi alone.
- R9: With wide=0 the mode bits have no effect. A write drives {0x00, byte} and raises wr_lo alone.
- R10: A read raises rd_stb for the whole busy window. No write strobe rises and bus_drive stays 0. A write raises bus_drive for its busy window.
- R11: An access uses the register value from before any write made in the same cycle as the request. A request made while busy is 1 or done is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| internal_only | input | 1 | Internal-only operation: control register locked |
| wide | input | 1 | 1 = 16-bit data bus, 0 = 8-bit |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register contents |
| req_valid | input | 1 | Access request, taken in ST_IDLE |
| req_write | input | 1 | 1 = table write, 0 = table read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | Bus cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_own | output | 1 | Pins belong to the bus (0 = general I/O) |
| bus_addr | output | ADDR_W | Address on the bus |
| bus_dout | output | 16 | Data lanes, high byte in [15:8] |
| bus_drive | output | 1 | Data lane output enable |
| wr_hi | output | 1 | High-byte write strobe |
| wr_lo | output | 1 | Low-byte write strobe |
| en_hi | output | 1 | Upper byte enable |
| en_lo | output | 1 | Lower byte enable |
| rd_stb | output | 1 | Read strobe |

## Verification
A control register write and an access request can land on the same clock edge. The bench makes this happen by raising cfg_we, with a new wait code, in the same cycle as req_valid. It then counts busy cycles to confirm that the access ran with the old wait count. It also reads cfg_rdata back afterwards to confirm that the new value was stored. A second request raised in the middle of an access checks that no extra busy window follows the done pulse.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    localparam int DATA_W = 8;
    localparam int BUS_W  = 2 * DATA_W;

    // register bit positions
    localparam int POS_REL  = 7;
    localparam int POS_WAIT = 4;
    localparam int POS_MODE = 0;

    // bits that hold state; the rest read as zero
    localparam logic [DATA_W-1:0] CFG_MASK = 8'b1011_0011;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_STALL,
        ST_FIN
    } ebc_state_e;

    typedef struct packed {
        logic       release_io;
        logic [1:0] wait_code;
        logic [1:0] wmode;
    } ebc_cfg_t;

    // wait code is inverted: 11 -> 0 waits, 00 -> 3 waits
    function automatic logic [1:0] wait_cycles(input logic [1:0] code);
        return ~code;
    endfunction

    function automatic logic is_word_mode(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/ebc_cfg_reg.sv
module ebc_cfg_reg
    import ebc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              lock,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ebc_cfg_t          cfg
);

    logic [DATA_W-1:0] reg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (we && !lock) begin
            reg_q <= wdata & CFG_MASK;
        end
    end

    assign rdata = reg_q;

    always_comb begin
        cfg.release_io = reg_q[POS_REL];
        cfg.wait_code  = reg_q[POS_WAIT +: 2];
        cfg.wmode      = reg_q[POS_MODE +: 2];
    end

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && lock) |=> $stable(reg_q)) else $error("locked register changed"); // R3

endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
    import ebc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              wide,
    input  ebc_cfg_t          cfg,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data,
    output logic [DATA_W-1:0] lo_hold,
    output logic              cap_write,
    output logic              cap_wide,
    output logic [1:0]        cap_mode
);

    ebc_state_e state_q, state_d;
    logic [1:0] cnt_q;
    logic       take;
    logic       latch_only;

    assign take       = (state_q == ST_IDLE) && req_valid;
    assign latch_only = req_write && wide && is_word_mode(cfg.wmode) && !req_addr[0];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = latch_only ? ST_FIN : ST_ACCESS;
            end
            ST_ACCESS: state_d = (cnt_q == 2'd0) ? ST_FIN : ST_STALL;
            ST_STALL:  state_d = (cnt_q == 2'd0) ? ST_FIN : ST_STALL;
            ST_FIN:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            cap_addr  <= '0;
            cap_data  <= '0;
            lo_hold   <= '0;
            cap_write <= 1'b0;
            cap_wide  <= 1'b0;
            cap_mode  <= '0;
        end else if (take) begin
            cnt_q     <= wait_cycles(cfg.wait_code);
            cap_addr  <= req_addr;
            cap_data  <= req_wdata;
            cap_write <= req_write;
            cap_wide  <= wide;
            cap_mode  <= cfg.wmode;
            if (latch_only) lo_hold <= req_wdata;
        end else if (state_q != ST_IDLE && cnt_q != 2'd0) begin
            cnt_q <= cnt_q - 2'd1;
        end
    end

    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ACCESS: busy = 1'b1;
            ST_STALL:  busy = 1'b1;
            ST_FIN:    done = 1'b1;
            default:   ;
        endcase
    end

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy) else $error("done while busy"); // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R5
    AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> $stable(cap_addr)) else $error("request taken while busy"); // R11

endmodule

// File: rtl/ebc_lanes.sv
module ebc_lanes
    import ebc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              is_write,
    input  logic              wide,
    input  logic [1:0]        mode,
    input  logic              a0,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] lo_hold,
    output logic [BUS_W-1:0]  dout,
    output logic              drive,
    output logic              wr_hi,
    output logic              wr_lo,
    output logic              en_hi,
    output logic              en_lo,
    output logic              rd_stb
);

    always_comb begin
        dout   = '0;
        drive  = 1'b0;
        wr_hi  = 1'b0;
        wr_lo  = 1'b0;
        en_hi  = 1'b0;
        en_lo  = 1'b0;
        rd_stb = 1'b0;
        if (active) begin
            if (!is_write) begin
                rd_stb = 1'b1;
            end else begin
                drive = 1'b1;
                if (!wide) begin
                    dout  = {{DATA_W{1'b0}}, data};
                    wr_lo = 1'b1;
                end else if (is_word_mode(mode)) begin
                    dout  = {data, lo_hold};
                    wr_hi = 1'b1;
                end else if (mode[0]) begin
                    dout  = {data, data};
                    wr_hi = 1'b1;
                    en_hi = a0;
                    en_lo = !a0;
                end else begin
                    dout  = {data, data};
                    wr_hi = a0;
                    wr_lo = !a0;
                end
            end
        end
    end

    AST_ENABLE_WITH_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (en_hi || en_lo) |-> (wr_hi && !wr_lo)) else $error("enable without high strobe"); // R7
    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en_hi, en_lo})) else $error("both enables"); // R7
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> !(wr_hi || wr_lo || drive)) else $error("read with write strobe"); // R10

endmodule

// File: rtl/ext_bus_ctl.sv
module ext_bus_ctl
    import ebc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              internal_only,
    input  logic              wide,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              busy,
    output logic              done,
    output logic              bus_own,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [15:0]       bus_dout,
    output logic              bus_drive,
    output logic              wr_hi,
    output logic              wr_lo,
    output logic              en_hi,
    output logic              en_lo,
    output logic              rd_stb
);

    ebc_cfg_t          cfg;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    logic [DATA_W-1:0] lo_hold;
    logic              cap_write;
    logic              cap_wide;
    logic [1:0]        cap_mode;

    ebc_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .lock  (internal_only),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    ebc_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .wide      (wide),
        .cfg       (cfg),
        .busy      (busy),
        .done      (done),
        .cap_addr  (cap_addr),
        .cap_data  (cap_data),
        .lo_hold   (lo_hold),
        .cap_write (cap_write),
        .cap_wide  (cap_wide),
        .cap_mode  (cap_mode)
    );

    ebc_lanes u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (busy),
        .is_write (cap_write),
        .wide     (cap_wide),
        .mode     (cap_mode),
        .a0       (cap_addr[0]),
        .data     (cap_data),
        .lo_hold  (lo_hold),
        .dout     (bus_dout),
        .drive    (bus_drive),
        .wr_hi    (wr_hi),
        .wr_lo    (wr_lo),
        .en_hi    (en_hi),
        .en_lo    (en_lo),
        .rd_stb   (rd_stb)
    );

    assign bus_own  = !cfg.release_io || busy;
    assign bus_addr = cap_addr;

    AST_OWN_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> bus_own) else $error("bus not owned during access"); // R4
    AST_STROBE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi || wr_lo || rd_stb || bus_drive) |-> busy) else $error("strobe outside access"); // R5

endmodule

// File: tb/ext_bus_ctl_bench.sv
module ext_bus_ctl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          internal_only = 1'b0;
    logic          wide = 1'b1;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_wdata = '0;
    logic          busy, done, bus_own, bus_drive;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_dout;
    logic          wr_hi, wr_lo, en_hi, en_lo, rd_stb;

    int n_checks = 0;
    int n_fail = 0;

    ext_bus_ctl #(.ADDR_W(AW)) u_ext_bus_ctl (
        .clk(clk), .rst_n(rst_n), .internal_only(internal_only), .wide(wide),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .done(done), .bus_own(bus_own),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_drive(bus_drive),
        .wr_hi(wr_hi), .wr_lo(wr_lo), .en_hi(en_hi), .en_lo(en_lo), .rd_stb(rd_stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // strobes packed as {wr_hi, wr_lo, en_hi, en_lo, rd_stb}
    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [7:0] d,
                          output int nbusy, output logic [15:0] dv, output logic [4:0] st,
                          output logic drv, output logic own, output logic dn,
                          output logic post_st);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        dv = bus_dout; st = {wr_hi, wr_lo, en_hi, en_lo, rd_stb};
        drv = bus_drive; own = bus_own;
        nbusy = 0;
        while (busy && nbusy < 20) begin
            nbusy++;
            @(negedge clk);
        end
        dn = done;
        post_st = wr_hi | wr_lo | rd_stb | en_hi | en_lo;
    endtask

    task automatic t_reset();
        chk("R1 cfg_rdata", cfg_rdata, 8'h00);
        chk("R1 busy/done", {busy, done}, 2'b00);
        chk("R1 bus_own", bus_own, 1'b1);
        chk("R1 strobes", {wr_hi, wr_lo, en_hi, en_lo, rd_stb, bus_drive}, 6'b0);
    endtask

    task automatic t_cfg();
        cfg_write(8'hFF);
        chk("R2 unused bits zero", cfg_rdata, 8'hB3);
        cfg_write(8'h4C);
        chk("R2 only unused bits", cfg_rdata, 8'h00);
        internal_only = 1'b1;
        cfg_write(8'h31);
        chk("R3 write ignored", cfg_rdata, 8'h00);
        internal_only = 1'b0;
        cfg_write(8'h31);
        chk("R2 write accepted", cfg_rdata, 8'h31);
    endtask

    task automatic t_wait();
        int nb; logic [15:0] dv; logic [4:0] st; logic drv, own, dn, ps;
        for (int c = 0; c < 4; c++) begin
            cfg_write(8'(c << 4));
            access(1'b0, 16'h0100, 8'h00, nb, dv, st, drv, own, dn, ps);
            chk($sformatf("R5 busy len code %0d", c), nb, 32'(1 + (3 - c)));
            chk("R5 done after busy", dn, 1'b1);
            chk("R5 strobes low at done", ps, 1'b0);
            chk("R10 read strobe only", st, 5'b00001);
            chk("R10 no drive on read", drv, 1'b0);
        end
    endtask

    task automatic t_own();
        int nb; logic [15:0] dv; logic [4:0] st; logic drv, own, dn, ps;
        cfg_write(8'h30);
        chk("R4 owned when not released", bus_own, 1'b1);
        cfg_write(8'hB0);
        chk("R4 released idle", bus_own, 1'b0);
        access(1'b0, 16'h0002, 8'h00, nb, dv, st, drv, own, dn, ps);
        chk("R4 owned during access", own, 1'b1);
        chk("R4 released after access", bus_own, 1'b0);
    endtask

    task automatic t_bytewrite();
        int nb; logic [15:0] dv; logic [4:0] st; logic drv, own, dn, ps;
        wide = 1'b1;
        cfg_write(8'h30);
        access(1'b1, 16'h0010, 8'hA5, nb, dv, st, drv, own, dn, ps);
        chk("R6 even data", dv, 16'hA5A5);
        chk("R6 even strobe", st, 5'b01000);
        chk("R10 drive on write", drv, 1'b1);
        access(1'b1, 16'h0011, 8'h3C, nb, dv, st, drv, own, dn, ps);
        chk("R6 odd data", dv, 16'h3C3C);
        chk("R6 odd strobe", st, 5'b10000);
    endtask

    task automatic t_bytesel();
        int nb; logic [15:0] dv; logic [4:0] st; logic drv, own, dn, ps;
        cfg_write(8'h31);
        access(1'b1, 16'h0020, 8'h5A, nb, dv, st, drv, own, dn, ps);
        chk("R7 even data", dv, 16'h5A5A);
        chk("R7 even strobe", st, 5'b10010);
        access(1'b1, 16'h0021, 8'h77, nb, dv, st, drv, own, dn, ps);
        chk("R7 odd strobe", st, 5'b10100);
    endtask

    task automatic t_word();
        int nb; logic [15:0] dv; logic [4:0] st; logic drv, own, dn, ps;
        cfg_write(8'h32);
        access(1'b1, 16'h0040, 8'h11, nb, dv, st, drv, own, dn, ps);
        chk("R8 even no busy", nb, 0);
        chk("R8 even done", dn, 1'b1);
        chk("R8 even no strobe", st, 5'b0);
        access(1'b1, 16'h0041, 8'h22, nb, dv, st, drv, own, dn, ps);
        chk("R8 word data", dv, 16'h2211);
        chk("R8 word strobe", st, 5'b10000);
        cfg_write(8'h33);
        access(1'b1, 16'h0042, 8'h9E, nb, dv, st, drv, own, dn, ps);
        access(1'b1, 16'h0043, 8'h4D, nb, dv, st, drv, own, dn, ps);
        chk("R8 mode 11 word data", dv, 16'h4D9E);
    endtask

    task automatic t_narrow();
        int nb; logic [15:0] dv; logic [4:0] st; logic drv, own, dn, ps;
        wide = 1'b0;
        cfg_write(8'h32);
        access(1'b1, 16'h0050, 8'hC3, nb, dv, st, drv, own, dn, ps);
        chk("R9 narrow even busy", nb, 1);
        chk("R9 narrow data", dv, 16'h00C3);
        chk("R9 narrow strobe", st, 5'b01000);
        cfg_write(8'h31);
        access(1'b1, 16'h0051, 8'h81, nb, dv, st, drv, own, dn, ps);
        chk("R9 narrow odd strobe", st, 5'b01000);
        wide = 1'b1;
    endtask

    task automatic t_overlap();
        int nb;
        cfg_write(8'h00);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 8'h30;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0060;
        @(negedge clk);
        cfg_we = 1'b0;
        nb = 0;
        while (busy && nb < 20) begin
            nb++;
            if (nb == 2) req_valid = 1'b1;
            else req_valid = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R11 old wait used", nb, 4);
        chk("R11 new value stored", cfg_rdata, 8'h30);
        @(negedge clk);
        chk("R11 mid request ignored", busy, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_wait();
        t_own();
        t_bytewrite();
        t_bytesel();
        t_word();
        t_narrow();
        t_overlap();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule